// File: doc/BRIEF.md
# AES-128 Round-Key Step Unit

This unit takes one 128-bit AES-128 round key and a 5-bit immediate, and returns the round key that follows it in the forward key schedule. It handles one element group at a time. Groups enter through a valid/ready input port and leave through a registered valid/ready output port. Each accepted group yields exactly one result, one cycle after it is accepted.

The immediate selects the round number. Only its low four bits are used. A low nibble outside 1..10 is moved into range by flipping its bit 3, and the folded round then picks the round constant. The first new word uses the top word of the current key, byte-rotated and passed through the AES S-box, together with that round constant. Each later word is chained from the word produced just before it.

Top module: `aes128_key_step`

## Requirements
- R1: Bit 4 of `in_imm` has no effect: two groups whose keys are equal and whose immediates differ only in bit 4 give identical `out_key`.
- R2: A low nibble of 1 to 10 is used as the round number directly. The round constant for round r is 0x01 doubled r-1 times in GF(2^8) modulo x^8+x^4+x^3+x+1, which gives 01,02,04,08,10,20,40,80,1B,36. It is placed in bits 7:0 of the constant word, with the upper 24 bits zero.
- R3: A low nibble of 0 or 11 to 15 is replaced by the same nibble with bit 3 inverted (0→8, 11→3, 12→4, 13→5, 14→6, 15→7). The result equals that of the folded round.
- R4: Word i of a key occupies bits 32i+31:32i, and byte k of a word occupies bits 8k+7:8k. New word 0 = w0 XOR SubWord(RotWord(w3)) XOR rcon. RotWord moves byte 0 of w3 to byte 3 and shifts the other bytes down one place. SubWord applies the AES S-box to each byte, so S(0x00)=0x63 and S(0x53)=0xED.
- R5: New word i (i = 1..3) = wi XOR new word i-1.
- R6: `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A group accepted on a clock edge sets `out_valid` high after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_key` does not change.
- R8: During reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Unit can accept a group |
| in_key | input | 128 | Current round key, word i at bits 32i+31:32i |
| in_imm | input | 5 | Round-number immediate; bit 4 unused |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Downstream takes the result |
| out_key | output | 128 | Next round key |

## Verification
The bench builds the unit with its default parameters: four 32-bit words and a 5-bit immediate. With only 32 possible immediates, every immediate is applied to each of eight keys. This covers every in-range round, every folded value and both settings of the ignored bit. The bench computes its own S-box from logarithm tables and checks one published AES-128 first-round expansion as a known answer. Random back-pressure on `out_ready` exercises the hold and drain behaviour of the output register.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] GF_POLY_LO = 8'h1b;

  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? GF_POLY_LO : '0);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

endpackage

// File: rtl/ks_round_fold.sv
module ks_round_fold #(
  parameter int RND_W = 4,
  parameter int MAX_ROUND = 10
) (
  input  logic [RND_W-1:0]             nib,
  output logic [RND_W-1:0]             round,
  output logic [aes_ks_pkg::BYTE_W-1:0] rcon
);
  import aes_ks_pkg::*;

  logic out_of_range;

  always_comb begin
    out_of_range = (nib == '0) || (int'(nib) > MAX_ROUND);
    round        = out_of_range ? {~nib[RND_W-1], nib[RND_W-2:0]} : nib;
  end

  // constant = 0x01 doubled (round-1) times
  always_comb begin
    rcon = 8'h01;
    for (int k = 1; k < (1 << RND_W); k++) begin
      if (k < int'(round)) rcon = gf_dbl(rcon);
    end
  end

  always_comb begin
    a_r3_round_in_range: assert (int'(round) >= 1 && int'(round) <= MAX_ROUND)
      else $error("folded round out of range");
    a_r2_rcon_nonzero: assert (rcon != '0)
      else $error("round constant is zero");
  end

endmodule

// File: rtl/ks_sbox.sv
module ks_sbox (
  input  logic [aes_ks_pkg::BYTE_W-1:0] din,
  output logic [aes_ks_pkg::BYTE_W-1:0] dout
);
  import aes_ks_pkg::*;

  localparam logic [BYTE_W-1:0] AFF_C   = 8'h63;
  localparam int                INV_EXP = 254;

  logic [BYTE_W-1:0] inv;

  // multiplicative inverse as din^254 (zero maps to zero)
  always_comb begin
    logic [BYTE_W-1:0] base;
    inv  = 8'h01;
    base = din;
    for (int i = 0; i < BYTE_W; i++) begin
      if (((INV_EXP >> i) & 1) != 0) inv = gf_mul(inv, base);
      base = gf_mul(base, base);
    end
  end

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) begin
      dout[i] = inv[i] ^ inv[(i + 4) % BYTE_W] ^ inv[(i + 5) % BYTE_W] ^
                inv[(i + 6) % BYTE_W] ^ inv[(i + 7) % BYTE_W] ^ AFF_C[i];
    end
  end

endmodule

// File: rtl/ks_next_key.sv
module ks_next_key #(
  parameter int NWORDS = 4,
  parameter int WORD_W = 32
) (
  input  logic [NWORDS*WORD_W-1:0]      cur_key,
  input  logic [aes_ks_pkg::BYTE_W-1:0] rcon,
  output logic [NWORDS*WORD_W-1:0]      nxt_key
);
  import aes_ks_pkg::*;

  localparam int NBYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] top_w;
  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] sub_w;
  logic [WORD_W-1:0] nw [NWORDS];

  assign top_w = cur_key[NWORDS*WORD_W-1 -: WORD_W];
  assign rot_w = {top_w[BYTE_W-1:0], top_w[WORD_W-1:BYTE_W]};

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    ks_sbox u_sbox (
      .din  (rot_w[b*BYTE_W +: BYTE_W]),
      .dout (sub_w[b*BYTE_W +: BYTE_W])
    );
  end

  assign nw[0] = cur_key[WORD_W-1:0] ^ sub_w ^ {{(WORD_W-BYTE_W){1'b0}}, rcon};

  for (genvar w = 1; w < NWORDS; w++) begin : g_chain
    assign nw[w] = cur_key[w*WORD_W +: WORD_W] ^ nw[w-1];
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_pack
    assign nxt_key[w*WORD_W +: WORD_W] = nw[w];
  end

endmodule

// File: rtl/aes128_key_step.sv
module aes128_key_step #(
  parameter int NWORDS = 4,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NWORDS*WORD_W-1:0] in_key,
  input  logic [IMM_W-1:0]         in_imm,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NWORDS*WORD_W-1:0] out_key
);
  import aes_ks_pkg::*;

  localparam int KEY_W = NWORDS * WORD_W;
  localparam int RND_W = 4;

  logic              unused_imm_hi;
  logic [RND_W-1:0]  round;
  logic [BYTE_W-1:0] rcon;
  logic [KEY_W-1:0]  nxt_key;
  logic              accept;
  logic              valid_d, valid_q;
  logic [KEY_W-1:0]  key_q;

  assign unused_imm_hi = ^in_imm[IMM_W-1:RND_W];

  ks_round_fold #(.RND_W(RND_W), .MAX_ROUND(10)) u_fold (
    .nib   (in_imm[RND_W-1:0]),
    .round (round),
    .rcon  (rcon)
  );

  ks_next_key #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_next (
    .cur_key (in_key),
    .rcon    (rcon),
    .nxt_key (nxt_key)
  );

  // next-state
  always_comb begin
    in_ready = !valid_q || out_ready;
    accept   = in_valid && in_ready;
    if (accept)         valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (accept) key_q <= nxt_key;
  end

  assign out_valid = valid_q;
  assign out_key   = key_q;

  a_r6_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted group did not reach output");

  a_r6_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid)
    else $error("drained output still valid");

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_key)))
    else $error("stalled output changed");

  a_r5_chain_word1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      ((out_key[2*WORD_W-1:WORD_W] ^ out_key[WORD_W-1:0]) == $past(in_key[2*WORD_W-1:WORD_W])))
    else $error("word 1 not chained from word 0");

endmodule

// File: tb/aes128_key_step_test.sv
module aes128_key_step_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_key;
  logic [4:0]   in_imm;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_key;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] exp_t [256];
  logic [7:0] log_t [256];
  logic [31:0] lcg = 32'h1234_5678;

  logic [127:0] expq [$];
  string        reqq [$];
  bit           hold_pending = 0;
  logic [127:0] held_key;
  bit           expect_valid = 0;
  bit           acc;

  aes128_key_step uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_imm(in_imm), .out_valid(out_valid),
    .out_ready(out_ready), .out_key(out_key)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  task automatic build_tables();
    logic [7:0] v;
    v = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = v;
      log_t[v] = i[7:0];
      v = v ^ xt(v);
    end
    exp_t[255] = 8'h01;
    log_t[0]   = 8'h00;
  endtask

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int s);
    return (a << s) | (a >> (8 - s));
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [7:0] iv;
    iv = (x == 0) ? 8'h00 : exp_t[(255 - int'(log_t[x])) % 255];
    return iv ^ rotl8(iv, 1) ^ rotl8(iv, 2) ^ rotl8(iv, 3) ^ rotl8(iv, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] rc(input int r);
    if (r <= 8) return 8'h01 << (r - 1);
    return (r == 9) ? 8'h1b : 8'h36;
  endfunction

  function automatic int fold(input logic [4:0] imm);
    int n;
    n = int'(imm[3:0]);
    if (n == 0 || n > 10) n = n ^ 8;
    return n;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] k, input logic [4:0] imm);
    logic [31:0] w [4];
    logic [31:0] n [4];
    logic [31:0] r, s;
    for (int i = 0; i < 4; i++) w[i] = k[32*i +: 32];
    r = {w[3][7:0], w[3][31:8]};
    for (int b = 0; b < 4; b++) s[8*b +: 8] = sb(r[8*b +: 8]);
    n[0] = w[0] ^ s ^ {24'h0, rc(fold(imm))};
    for (int i = 1; i < 4; i++) n[i] = w[i] ^ n[i-1];
    return {n[3], n[2], n[1], n[0]};
  endfunction

  function automatic logic [31:0] bs(input logic [31:0] a);
    return {a[7:0], a[15:8], a[23:16], a[31:24]};
  endfunction

  function automatic string req_of(input logic [4:0] imm);
    int n;
    n = int'(imm[3:0]);
    if (n == 0 || n > 10) return imm[4] ? "R1 R3 R4 R5" : "R3 R4 R5";
    return imm[4] ? "R1 R2 R4 R5" : "R2 R4 R5";
  endfunction

  // evaluates the handshakes that the coming rising edge will perform
  task automatic judge();
    logic [127:0] e;
    string        rq;
    acc = 0;
    if (expect_valid) chk(out_valid == 1'b1, "R6 latency", {127'h0, out_valid}, 128'h1);
    expect_valid = 0;
    if (hold_pending) begin
      chk(out_valid == 1'b1, "R7 valid held", {127'h0, out_valid}, 128'h1);
      chk(out_key == held_key, "R7 key held", out_key, held_key);
    end
    hold_pending = out_valid && !out_ready;
    held_key     = out_key;
    chk(in_ready == (!out_valid || out_ready), "R6 ready", {127'h0, in_ready},
        {127'h0, (!out_valid || out_ready)});
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R6 unexpected output", out_key, 128'h0);
      end else begin
        e  = expq.pop_front();
        rq = reqq.pop_front();
        chk(out_key == e, rq, out_key, e);
      end
    end
    if (in_valid && in_ready) begin
      expq.push_back(model(in_key, in_imm));
      reqq.push_back(req_of(in_imm));
      expect_valid = 1;
      acc = 1;
    end
  endtask

  task automatic step(input bit rdy_rand);
    @(negedge clk);
    out_ready = rdy_rand ? (nxt_rand() >> 28) != 4'h0 : 1'b1;
    #1 judge();
  endtask

  task automatic send(input logic [127:0] k, input logic [4:0] imm);
    @(negedge clk);
    in_valid  = 1'b1;
    in_key    = k;
    in_imm    = imm;
    out_ready = (nxt_rand() >> 28) != 4'h0;
    #1 judge();
    while (!acc) step(1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] kat_in, kat_out, k;
    logic [127:0] keys [8];
    build_tables();
    rst_n = 1'b0; in_valid = 1'b0; in_key = '0; in_imm = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R8 reset valid", {127'h0, out_valid}, 128'h0);
    chk(in_ready == 1'b1, "R8 reset ready", {127'h0, in_ready}, 128'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // independent anchors for the bench model
    chk(sb(8'h00) == 8'h63, "R4 sbox 00", {120'h0, sb(8'h00)}, 128'h63);
    chk(sb(8'h53) == 8'hed, "R4 sbox 53", {120'h0, sb(8'h53)}, 128'hed);
    kat_in  = {bs(32'h09cf4f3c), bs(32'habf71588), bs(32'h28aed2a6), bs(32'h2b7e1516)};
    kat_out = {bs(32'h2a6c7605), bs(32'h23a33939), bs(32'h88542cb1), bs(32'ha0fafe17)};
    chk(model(kat_in, 5'd1) == kat_out, "R4 known answer model", model(kat_in, 5'd1), kat_out);

    keys[0] = kat_in;
    keys[1] = '0;
    keys[2] = '1;
    for (int i = 3; i < 8; i++) begin
      k = {nxt_rand(), nxt_rand(), nxt_rand(), nxt_rand()};
      keys[i] = k;
    end

    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 32; m++) send(keys[i], m[4:0]);
    end

    // drain
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1 judge();
    for (int g = 0; g < 20 && expq.size() != 0; g++) step(1'b0);
    chk(expq.size() == 0, "R6 all results delivered", expq.size(), 128'h0);

    // direct known answer through the device
    send(kat_in, 5'd1);
    @(negedge clk);
    in_valid = 1'b0;
    #1 judge();
    for (int g = 0; g < 20 && expq.size() != 0; g++) step(1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule